// File: doc/BRIEF.md
# Two-Wire Open-Drain Serial Shifter

This block moves one byte at a time over a single shared data wire that is driven open-drain, next to a serial clock. A write to the shift register starts a transfer. On each falling clock edge the output latch takes the register's top bit, so the line carries the data most-significant bit first. On each rising edge the level of the line is shifted into the register's low end. The same register therefore ends up holding the wire-AND of what this block sent and what any other device on the line sent. After eight bits the engine stops by itself and raises a completion flag.

The block never drives the data line high. It only enables a pull-down (`sda_pull_low`), and an external pull-up supplies the high level. To receive only, software loads all ones first, so the latch keeps the line released. While the engine is idle, two single-cycle control pulses set the output latch directly. One releases the line and the other pulls it low. The serial clock comes either from an internal divider, idling high, or from an external pin. The external clock passes through a two-flop synchronizer and an edge detector.

Top module: `sio_2wire_shifter`

## Requirements
- R1: In internal-clock mode a write to the shift register while idle sets `busy`, and `busy` stays high for exactly 16*(clk_div+1) system clock cycles. Each half period of the serial clock is clk_div+1 cycles long.
- R2: On each falling serial clock edge the output latch loads bit 7 of the shift register, so the line carries the written byte MSB first. `sda_pull_low` is the inverse of the latch (1 = pull low).
- R3: On each rising serial clock edge the line level `sda_in` is shifted into bit 0. After the transfer, `sr_rdata` equals the sent byte ANDed with the byte another device drove onto the line.
- R4: After the eighth rising edge the shifting stops, `busy` falls and `done_flag` goes to 1 in the same cycle.
- R5: When 8'hFF is written with the latch released, `sda_pull_low` stays 0 for the whole transfer.
- R6: While idle, a `rel_pulse` sets the latch to 1 and a `cmd_pulse` sets it to 0. If both are high in the same cycle, the latch goes to 0.
- R7: `rel_pulse` and `cmd_pulse` have no effect while `busy` is high.
- R8: A write to the shift register while `busy` is high is ignored: neither the data nor the timing of the running transfer changes.
- R9: A `flag_clr` pulse clears `done_flag`. If `flag_clr` comes in the same cycle as the end of a transfer, the flag is set.
- R10: Starting a new transfer clears `done_flag` in the same cycle that `busy` rises.
- R11: In external-clock mode (`ext_clk_mode`=1) the shifting follows the edges of `sck_in`, and `sck_oe` is 0. In internal mode `sck_oe` is 1.
- R12: In internal-clock mode `sck_out` is 1 whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_mode | input | 1 | 1 = serial clock from `sck_in`, 0 = internal divider |
| clk_div | input | DIVW | Half-period length minus one, in system clock cycles |
| sr_wr | input | 1 | Write strobe for the shift register |
| sr_wdata | input | W | Byte to send |
| sr_rdata | output | W | Shift register contents |
| rel_pulse | input | 1 | Idle-time release: latch to 1 |
| cmd_pulse | input | 1 | Idle-time command: latch to 0 |
| flag_clr | input | 1 | Clears the completion flag |
| busy | output | 1 | Transfer in progress |
| done_flag | output | 1 | Completion interrupt flag |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internal serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| sda_in | input | 1 | Level of the shared data line |
| sda_pull_low | output | 1 | Open-drain pull-down enable |

## Verification
Two functions can fall in the same cycle: the end of a transfer, which sets the completion flag, and a software clear of that flag. The bench uses a divider of zero, which makes the last rising edge land exactly 16 cycles after the write. It raises `flag_clr` so that the clear is sampled on that same edge. The flag must then read 1, and a later lone clear must bring it to 0. The other collision is a control pulse or a second write that arrives mid-transfer. It is judged by watching the line and the received byte.

// File: rtl/sio_2wire_shifter.sv
module sio_2wire_shifter #(
  parameter int W    = 8,
  parameter int DIVW = 8,
  localparam int BCW = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_clk_mode,
  input  logic [DIVW-1:0] clk_div,
  input  logic            sr_wr,
  input  logic [W-1:0]    sr_wdata,
  output logic [W-1:0]    sr_rdata,
  input  logic            rel_pulse,
  input  logic            cmd_pulse,
  input  logic            flag_clr,
  output logic            busy,
  output logic            done_flag,
  input  logic            sck_in,
  output logic            sck_out,
  output logic            sck_oe,
  input  logic            sda_in,
  output logic            sda_pull_low
);

  logic [W-1:0]    sr;
  logic            out_latch;
  logic            busy_q;
  logic            flag_q;
  logic [DIVW-1:0] cnt;
  logic            sck_int;
  logic [2:0]      ext_sync;
  logic [BCW-1:0]  bits;

  wire ext_now  = ext_sync[1];
  wire ext_prev = ext_sync[2];
  wire tick     = busy_q && !ext_clk_mode && (cnt == clk_div);
  wire fall_ev  = ext_clk_mode ? (busy_q && ext_prev && !ext_now) : (tick && sck_int);
  wire rise_ev  = ext_clk_mode ? (busy_q && !ext_prev && ext_now) : (tick && !sck_int);
  wire start    = sr_wr && !busy_q;
  wire last     = rise_ev && (bits == BCW'(W - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_sync <= 3'b111;
    else        ext_sync <= {ext_sync[1:0], sck_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (!busy_q) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       sck_int <= 1'b1;
    else if (!busy_q) sck_int <= 1'b1;
    else if (tick)    sck_int <= ~sck_int;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       sr <= '0;
    else if (start)   sr <= sr_wdata;
    else if (rise_ev) sr <= {sr[W-2:0], sda_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         out_latch <= 1'b1;
    else if (busy_q) begin
      if (fall_ev)      out_latch <= sr[W-1];
    end
    else if (cmd_pulse) out_latch <= 1'b0;
    else if (rel_pulse) out_latch <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     busy_q <= 1'b0;
    else if (start) busy_q <= 1'b1;
    else if (last)  busy_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       bits <= '0;
    else if (start)   bits <= '0;
    else if (rise_ev) bits <= bits + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         flag_q <= 1'b0;
    else if (last)      flag_q <= 1'b1;
    else if (start)     flag_q <= 1'b0;
    else if (flag_clr)  flag_q <= 1'b0;

  assign sr_rdata     = sr;
  assign busy         = busy_q;
  assign done_flag    = flag_q;
  assign sck_out      = sck_int;
  assign sck_oe       = !ext_clk_mode;
  assign sda_pull_low = !out_latch;

  p_sck_idle_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ext_clk_mode) |-> sck_out);

  p_flag_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);

  p_start_clears_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done_flag);

  p_ctrl_ignored_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_ev) |=> $stable(sda_pull_low));

  p_write_ignored_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rise_ev) |=> $stable(sr_rdata));

  p_idle_cmd_pulls_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sr_wr && cmd_pulse) |=> sda_pull_low);

endmodule

// File: tb/test_sio_2wire_shifter.sv
module test_sio_2wire_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk_mode = 1'b0;
  logic [7:0] clk_div = 8'd0;
  logic sr_wr = 1'b0;
  logic [7:0] sr_wdata = 8'h00;
  logic [7:0] sr_rdata;
  logic rel_pulse = 1'b0, cmd_pulse = 1'b0, flag_clr = 1'b0;
  logic busy, done_flag, sck_out, sck_oe, sda_pull_low;
  logic sck_ext = 1'b1;
  logic sda_line;

  logic slave_en = 1'b0;
  logic [7:0] slave_byte = 8'hFF;
  logic [3:0] slave_idx;
  logic [7:0] seen;
  logic pulled_in_xfer;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  sio_2wire_shifter i_sio_2wire_shifter (
    .clk(clk), .rst_n(rst_n), .ext_clk_mode(ext_clk_mode), .clk_div(clk_div),
    .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
    .rel_pulse(rel_pulse), .cmd_pulse(cmd_pulse), .flag_clr(flag_clr),
    .busy(busy), .done_flag(done_flag), .sck_in(sck_ext), .sck_out(sck_out),
    .sck_oe(sck_oe), .sda_in(sda_line), .sda_pull_low(sda_pull_low));

  wire sck_line = ext_clk_mode ? sck_ext : sck_out;
  wire slave_bit = (!slave_en || slave_idx == 4'd0) ? 1'b1 : slave_byte[4'd8 - slave_idx];
  assign sda_line = !sda_pull_low && slave_bit;

  always @(negedge sck_line or negedge slave_en)
    if (!slave_en) slave_idx <= 4'd0;
    else if (slave_idx < 4'd8) slave_idx <= slave_idx + 4'd1;

  always @(posedge sck_line or negedge slave_en)
    if (!slave_en) seen <= 8'h00;
    else seen <= {seen[6:0], !sda_pull_low};

  always @(negedge clk)
    if (!slave_en) pulled_in_xfer <= 1'b0;
    else if (busy && sda_pull_low) pulled_in_xfer <= 1'b1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_sr(input logic [7:0] d);
    @(negedge clk); sr_wdata = d; sr_wr = 1'b1;
    @(negedge clk); sr_wr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 20000) begin n++; @(negedge clk); end
  endtask

  task automatic xfer_int(input logic [7:0] tx, input logic [7:0] sl, input logic [7:0] dv,
                          input string tag);
    int n;
    @(negedge clk); clk_div = dv; slave_byte = sl; slave_en = 1'b1;
    write_sr(tx);
    wait_idle(n);
    check({tag, " R1 busy length"}, n, 16 * (dv + 1));
    check({tag, " R2 MSB-first line"}, seen, tx);
    check({tag, " R3 received wire-AND"}, sr_rdata, tx & sl);
    check({tag, " R4 flag at end"}, done_flag, 1'b1);
    check({tag, " R12 sck idle high"}, sck_out, 1'b1);
    @(negedge clk); slave_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R12 reset sck high", sck_out, 1'b1);
    check("R1 reset idle", busy, 1'b0);
    check("R9 reset flag", done_flag, 1'b0);
    check("R2 reset line released", sda_pull_low, 1'b0);
    check("R11 internal sck_oe", sck_oe, 1'b1);
  endtask

  task automatic t_idle_ctrl;
    @(negedge clk); cmd_pulse = 1'b1; @(negedge clk); cmd_pulse = 1'b0;
    check("R6 cmd pulls low", sda_pull_low, 1'b1);
    @(negedge clk); rel_pulse = 1'b1; @(negedge clk); rel_pulse = 1'b0;
    check("R6 rel releases", sda_pull_low, 1'b0);
    @(negedge clk); rel_pulse = 1'b1; cmd_pulse = 1'b1;
    @(negedge clk); rel_pulse = 1'b0; cmd_pulse = 1'b0;
    check("R6 both gives low", sda_pull_low, 1'b1);
    @(negedge clk); rel_pulse = 1'b1; @(negedge clk); rel_pulse = 1'b0;
  endtask

  task automatic t_receive_ff;
    int n;
    @(negedge clk); clk_div = 8'd2; slave_byte = 8'h3C; slave_en = 1'b1;
    write_sr(8'hFF);
    repeat (10) @(negedge clk);
    cmd_pulse = 1'b1; @(negedge clk); cmd_pulse = 1'b0;
    check("R7 cmd ignored while busy", sda_pull_low, 1'b0);
    wait_idle(n);
    check("R5 no pull during FF receive", pulled_in_xfer, 1'b0);
    check("R3 receive byte", sr_rdata, 8'h3C);
    @(negedge clk); slave_en = 1'b0;
  endtask

  task automatic t_rel_busy;
    int n;
    @(negedge clk); clk_div = 8'd3; slave_byte = 8'hFF; slave_en = 1'b1;
    write_sr(8'h00);
    repeat (12) @(negedge clk);
    rel_pulse = 1'b1; @(negedge clk); rel_pulse = 1'b0;
    check("R7 rel ignored while busy", sda_pull_low, 1'b1);
    wait_idle(n);
    check("R7 data intact", sr_rdata, 8'h00);
    @(negedge clk); slave_en = 1'b0;
    rel_pulse = 1'b1; @(negedge clk); rel_pulse = 1'b0;
  endtask

  task automatic t_write_busy;
    int n;
    @(negedge clk); clk_div = 8'd1; slave_byte = 8'hFF; slave_en = 1'b1;
    write_sr(8'hA5);
    repeat (5) @(negedge clk);
    sr_wdata = 8'h18; sr_wr = 1'b1; @(negedge clk); sr_wr = 1'b0;
    wait_idle(n);
    check("R8 busy length unchanged", n + 6, 32);
    check("R8 data unchanged", sr_rdata, 8'hA5);
    check("R8 line unchanged", seen, 8'hA5);
    @(negedge clk); slave_en = 1'b0;
  endtask

  task automatic t_flag_collide;
    @(negedge clk); clk_div = 8'd0; slave_en = 1'b1; slave_byte = 8'hFF;
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R9 clear works", done_flag, 1'b0);
    write_sr(8'hC3);
    repeat (15) @(negedge clk);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R9 end done", busy, 1'b0);
    check("R9 set wins over clear", done_flag, 1'b1);
    @(negedge clk); slave_en = 1'b0;
    write_sr(8'hFF);
    check("R10 start clears flag", done_flag, 1'b0);
    while (busy) @(negedge clk);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R9 lone clear", done_flag, 1'b0);
  endtask

  task automatic t_external;
    int n;
    @(negedge clk); ext_clk_mode = 1'b1; slave_byte = 8'h5A; slave_en = 1'b1;
    @(negedge clk);
    check("R11 ext sck_oe", sck_oe, 1'b0);
    write_sr(8'hF0);
    repeat (4) @(negedge clk);
    check("R11 waits for external clock", busy, 1'b1);
    for (int i = 0; i < 8; i++) begin
      sck_ext = 1'b0; repeat (6) @(negedge clk);
      sck_ext = 1'b1; repeat (6) @(negedge clk);
    end
    wait_idle(n);
    check("R11 ext done", done_flag, 1'b1);
    check("R11 ext line MSB first", seen, 8'hF0);
    check("R11 ext received", sr_rdata, 8'h50);
    @(negedge clk); slave_en = 1'b0; ext_clk_mode = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ctrl();
    xfer_int(8'hA5, 8'hFF, 8'd0, "pat1");
    xfer_int(8'h96, 8'hF0, 8'd3, "pat2");
    xfer_int(8'hFF, 8'h81, 8'd1, "pat3");
    t_receive_ff();
    t_rel_busy();
    t_write_busy();
    t_flag_collide();
    t_external();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule